// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block services translation misses for a TLB by walking a one-level page table held in memory. When the TLB reports a miss, the walker latches the faulting virtual address and the kind of access. It fetches the page-table entry for that virtual page from a table whose base address is held in a software-written register. For a present and permitted entry, it sets the entry's reference bit, and its dirty bit too on a write access. It stores the entry back only when one of those bits changed, then presents the translation as a one-cycle fill for the TLB to install before it retries the access. An entry that is not present, or a write to a page without write permission, ends the walk with a fault pulse instead, and the faulting address is latched for the exception handler.

A miss may arrive together with a dirty entry the TLB is about to evict. In that case the walker first performs a read-modify-write of the evicted page's entry, so that the page is marked modified in memory. Only then does it fetch the missing entry. All memory traffic goes through a single request/response port with at most one request in flight. While a walk is in progress the walker reports busy and ignores new misses.

Top module: `ptw_top`

## Requirements
- R1: After reset, busy, fill_valid, fault_valid, fault_prot and mem_req_valid are 0, bad_vaddr is 0 and the table base is 0.
- R2: The entry for virtual page number v is read from base + 4*v, where base is the last value written through base_we; the entry format is bit 0 present, bit 1 write permission, bit 2 referenced, bit 3 dirty, bits PA_W-1:12 physical page number (29:12 by default).
- R3: For a present entry that permits the access, fill_valid pulses for one cycle, one cycle after the last memory response of the walk, with fill_vpn equal to the miss page number, fill_ppn equal to the entry's page number field and fill_writable equal to its bit 1.
- R4: A successful walk sets bit 2 of the entry, and also bit 3 on a write miss; the updated entry is written back to the same address only if it differs from the fetched one, and fill_dirty reports its bit 3.
- R5: An entry with bit 0 clear produces a one-cycle fault_valid pulse with fault_prot 0, no fill and no write-back; bad_vaddr takes the full miss address and keeps it until the next fault.
- R6: A write miss to a present entry with bit 1 clear produces a fault with fault_prot 1, captures bad_vaddr, and writes nothing back.
- R7: When evict_dirty is high with an accepted miss, the entry at base + 4*evict_vpn is read first and written back with bit 3 set, unless bit 3 is already set, in which case the write is skipped; the miss entry is fetched afterwards.
- R8: busy is high from the cycle after a miss is accepted through the cycle of the fill or fault pulse, and is low in the following cycle; miss_valid while busy starts no memory access and no extra pulse.
- R9: mem_req_valid is a one-cycle pulse, and no new request is issued until the response to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | PA_W | New table base address |
| miss_valid | input | 1 | TLB miss request, accepted when not busy |
| miss_vaddr | input | VA_W | Virtual address that missed |
| miss_write | input | 1 | Missing access is a write |
| evict_dirty | input | 1 | A dirty TLB entry is displaced by this refill |
| evict_vpn | input | VA_W-12 | Virtual page number of the displaced entry |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Entry value read |
| fill_valid | output | 1 | Translation ready for the TLB |
| fill_vpn | output | VA_W-12 | Virtual page number of the fill |
| fill_ppn | output | PA_W-12 | Physical page number of the fill |
| fill_writable | output | 1 | Page permits writes |
| fill_dirty | output | 1 | Page is marked modified |
| fault_valid | output | 1 | Walk ended in a page fault |
| fault_prot | output | 1 | Fault was a write-permission violation |
| bad_vaddr | output | VA_W | Address of the last faulting access |

## Verification
Each memory request is due in the cycle after acceptance or after the previous response. The fill or fault pulse is due exactly one cycle after the final response, and busy falls one cycle after that pulse. The bench drives a memory model with a response latency of zero to three extra cycles, which stamps the cycle of every response. It samples outputs on the falling edge, compares the pulse cycle against the stamp plus one, and checks busy on the next falling edge. Read and write counts, the last read address and the table words are compared after each walk against values computed from the entry bits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W     = 32;
  localparam int BIT_PRES  = 0;
  localparam int BIT_WPERM = 1;
  localparam int BIT_REF   = 2;
  localparam int BIT_DIRTY = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EV_RD,
    ST_EV_WR,
    ST_PTE_RD,
    ST_PTE_WR,
    ST_FILL,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int PA_W = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PA_W-1:0] wdata,
  output logic [PA_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst) base <= '0;
    else if (we) base <= wdata;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IDX_W = 20,
  parameter int PA_W  = 30
) (
  input  logic [PA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);
  localparam int SHIFT = $clog2(ptw_pkg::PTE_W / 8);
  localparam int OFS_W = IDX_W + SHIFT;

  logic [OFS_W-1:0] ofs;
  assign ofs  = {idx, {SHIFT{1'b0}}};
  assign addr = base + PA_W'(ofs);
endmodule

// File: rtl/ptw_pte_update.sv
module ptw_pte_update
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0] pte_in,
  input  logic             is_write,
  output logic             present,
  output logic             prot_fault,
  output logic [PTE_W-1:0] pte_new,
  output logic             pte_changed,
  output logic [PTE_W-1:0] ev_marked,
  output logic             ev_was_dirty
);
  always_comb begin
    present     = pte_in[BIT_PRES];
    prot_fault  = pte_in[BIT_PRES] & is_write & ~pte_in[BIT_WPERM];
    pte_new     = pte_in;
    pte_new[BIT_REF] = 1'b1;
    if (is_write) pte_new[BIT_DIRTY] = 1'b1;
    pte_changed = (pte_new != pte_in);
    ev_marked   = pte_in;
    ev_marked[BIT_DIRTY] = 1'b1;
    ev_was_dirty = pte_in[BIT_DIRTY];
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 12,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             miss_valid,
  input  logic [VA_W-1:0]  miss_vaddr,
  input  logic             miss_write,
  input  logic             evict_dirty,
  input  logic [VPN_W-1:0] evict_vpn,
  output logic [VPN_W-1:0] lookup_idx,
  input  logic [PA_W-1:0]  lookup_addr,
  output logic             walk_write,
  input  logic             upd_present,
  input  logic             upd_prot_fault,
  input  logic [PTE_W-1:0] upd_pte_new,
  input  logic             upd_changed,
  input  logic [PTE_W-1:0] upd_ev_marked,
  input  logic             upd_ev_was_dirty,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  output logic             busy,
  output logic             fill_valid,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             fill_writable,
  output logic             fill_dirty,
  output logic             fault_valid,
  output logic             fault_prot,
  output logic [VA_W-1:0]  bad_vaddr
);
  walk_state_e      state_q;
  logic [VA_W-1:0]  vaddr_q;
  logic             wr_q;
  logic [VPN_W-1:0] ev_vpn_q;
  logic [PPN_W-1:0] ppn_q;
  logic             wperm_q;
  logic             dirty_q;

  // index of the entry the next request targets
  always_comb begin
    if (state_q == ST_IDLE)
      lookup_idx = evict_dirty ? evict_vpn : miss_vaddr[VA_W-1:PAGE_BITS];
    else if (state_q == ST_EV_RD && !upd_ev_was_dirty)
      lookup_idx = ev_vpn_q;
    else
      lookup_idx = vaddr_q[VA_W-1:PAGE_BITS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      vaddr_q       <= '0;
      wr_q          <= 1'b0;
      ev_vpn_q      <= '0;
      ppn_q         <= '0;
      wperm_q       <= 1'b0;
      dirty_q       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      fault_prot    <= 1'b0;
      bad_vaddr     <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (miss_valid) begin
          vaddr_q       <= miss_vaddr;
          wr_q          <= miss_write;
          ev_vpn_q      <= evict_vpn;
          mem_req_valid <= 1'b1;
          mem_req_write <= 1'b0;
          mem_req_addr  <= lookup_addr;
          state_q       <= evict_dirty ? ST_EV_RD : ST_PTE_RD;
        end
        ST_EV_RD: if (mem_rsp_valid) begin
          mem_req_valid <= 1'b1;
          mem_req_addr  <= lookup_addr;
          if (upd_ev_was_dirty) begin
            mem_req_write <= 1'b0;
            state_q       <= ST_PTE_RD;
          end else begin
            mem_req_write <= 1'b1;
            mem_req_wdata <= upd_ev_marked;
            state_q       <= ST_EV_WR;
          end
        end
        ST_EV_WR: if (mem_rsp_valid) begin
          mem_req_valid <= 1'b1;
          mem_req_write <= 1'b0;
          mem_req_addr  <= lookup_addr;
          state_q       <= ST_PTE_RD;
        end
        ST_PTE_RD: if (mem_rsp_valid) begin
          if (!upd_present || upd_prot_fault) begin
            bad_vaddr  <= vaddr_q;
            fault_prot <= upd_prot_fault;
            state_q    <= ST_FAULT;
          end else begin
            ppn_q   <= upd_pte_new[PA_W-1:PAGE_BITS];
            wperm_q <= upd_pte_new[BIT_WPERM];
            dirty_q <= upd_pte_new[BIT_DIRTY];
            if (upd_changed) begin
              mem_req_valid <= 1'b1;
              mem_req_write <= 1'b1;
              mem_req_addr  <= lookup_addr;
              mem_req_wdata <= upd_pte_new;
              state_q       <= ST_PTE_WR;
            end else begin
              state_q <= ST_FILL;
            end
          end
        end
        ST_PTE_WR: if (mem_rsp_valid) state_q <= ST_FILL;
        ST_FILL:   state_q <= ST_IDLE;
        ST_FAULT:  state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign walk_write    = wr_q;
  assign busy          = (state_q != ST_IDLE);
  assign fill_valid    = (state_q == ST_FILL);
  assign fault_valid   = (state_q == ST_FAULT);
  assign fill_vpn      = vaddr_q[VA_W-1:PAGE_BITS];
  assign fill_ppn      = ppn_q;
  assign fill_writable = wperm_q;
  assign fill_dirty    = dirty_q;

  logic waiting;
  assign waiting = (state_q == ST_EV_RD) || (state_q == ST_EV_WR) ||
                   (state_q == ST_PTE_RD) || (state_q == ST_PTE_WR);

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  a_r9_no_req_before_rsp: assert property (@(posedge clk) disable iff (rst)
    (waiting && !mem_rsp_valid) |=> !mem_req_valid);
  a_r3_fill_after_rsp: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $past(mem_rsp_valid));
  a_r8_busy_from_miss: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(miss_valid));
  a_r7_evict_marks_dirty: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EV_WR && mem_req_valid) |-> (mem_req_write && mem_req_wdata[BIT_DIRTY]));
  a_r4_update_sets_ref: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PTE_WR && mem_req_valid) |-> (mem_req_write && mem_req_wdata[BIT_REF]));
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 12,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             miss_valid,
  input  logic [VA_W-1:0]  miss_vaddr,
  input  logic             miss_write,
  input  logic             evict_dirty,
  input  logic [VPN_W-1:0] evict_vpn,
  output logic             busy,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_rdata,
  output logic             fill_valid,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PPN_W-1:0] fill_ppn,
  output logic             fill_writable,
  output logic             fill_dirty,
  output logic             fault_valid,
  output logic             fault_prot,
  output logic [VA_W-1:0]  bad_vaddr
);
  logic [PA_W-1:0]  base;
  logic [VPN_W-1:0] lookup_idx;
  logic [PA_W-1:0]  lookup_addr;
  logic             walk_write;
  logic             upd_present, upd_prot_fault, upd_changed, upd_ev_was_dirty;
  logic [PTE_W-1:0] upd_pte_new, upd_ev_marked;

  ptw_base_reg #(.PA_W(PA_W)) u_base (
    .clk(clk), .rst(rst), .we(base_we), .wdata(base_wdata), .base(base)
  );

  ptw_addr_gen #(.IDX_W(VPN_W), .PA_W(PA_W)) u_addr (
    .base(base), .idx(lookup_idx), .addr(lookup_addr)
  );

  ptw_pte_update u_upd (
    .pte_in(mem_rsp_rdata), .is_write(walk_write),
    .present(upd_present), .prot_fault(upd_prot_fault),
    .pte_new(upd_pte_new), .pte_changed(upd_changed),
    .ev_marked(upd_ev_marked), .ev_was_dirty(upd_ev_was_dirty)
  );

  ptw_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_write(miss_write),
    .evict_dirty(evict_dirty), .evict_vpn(evict_vpn),
    .lookup_idx(lookup_idx), .lookup_addr(lookup_addr), .walk_write(walk_write),
    .upd_present(upd_present), .upd_prot_fault(upd_prot_fault),
    .upd_pte_new(upd_pte_new), .upd_changed(upd_changed),
    .upd_ev_marked(upd_ev_marked), .upd_ev_was_dirty(upd_ev_was_dirty),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .busy(busy), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_writable(fill_writable), .fill_dirty(fill_dirty),
    .fault_valid(fault_valid), .fault_prot(fault_prot), .bad_vaddr(bad_vaddr)
  );
endmodule

// File: tb/ptw_top_test.sv
`timescale 1ns/1ps
module ptw_top_test;
  localparam int VA_W = 32, PA_W = 30, VPN_W = 20, PPN_W = 18;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             base_we = 1'b0;
  logic [PA_W-1:0]  base_wdata = '0;
  logic             miss_valid = 1'b0;
  logic [VA_W-1:0]  miss_vaddr = '0;
  logic             miss_write = 1'b0;
  logic             evict_dirty = 1'b0;
  logic [VPN_W-1:0] evict_vpn = '0;
  logic             busy, mem_req_valid, mem_req_write;
  logic [PA_W-1:0]  mem_req_addr;
  logic [31:0]      mem_req_wdata;
  logic             mem_rsp_valid = 1'b0;
  logic [31:0]      mem_rsp_rdata = '0;
  logic             fill_valid, fill_writable, fill_dirty, fault_valid, fault_prot;
  logic [VPN_W-1:0] fill_vpn;
  logic [PPN_W-1:0] fill_ppn;
  logic [VA_W-1:0]  bad_vaddr;

  ptw_top uut (.*);

  // memory model
  logic [31:0] mem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_idx = '0;
  logic [31:0] poke_data = '0;
  int          lat_cfg = 0;
  int          cyc = 0, rsp_cyc = 0, n_rd = 0, n_wr = 0, ovl = 0, cnt = 0;
  logic        pend = 1'b0;
  logic [31:0] rd_hold = '0;
  logic [PA_W-1:0] last_rd_addr = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (poke_en) mem[poke_idx] <= poke_data;
    if (mem_req_valid) begin
      if (pend || mem_rsp_valid) ovl <= ovl + 1;
      if (mem_req_write) begin
        n_wr <= n_wr + 1;
        mem[mem_req_addr[9:2]] <= mem_req_wdata;
      end else begin
        n_rd <= n_rd + 1;
        last_rd_addr <= mem_req_addr;
      end
      if (lat_cfg == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[9:2]];
        rsp_cyc <= cyc + 1;
      end else begin
        pend <= 1'b1;
        cnt <= lat_cfg - 1;
        rd_hold <= mem[mem_req_addr[9:2]];
      end
    end else if (pend) begin
      if (cnt == 0) begin
        pend <= 1'b0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= rd_hold;
        rsp_cyc <= cyc + 1;
      end else cnt <= cnt - 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [PA_W-1:0] cur_base = '0;
  logic [VA_W-1:0] last_fault_va = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(logic [7:0] idx, logic [31:0] d);
    poke_en = 1'b1; poke_idx = idx; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic set_base(logic [PA_W-1:0] b);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = b;
  endtask

  function automatic logic [7:0] widx(logic [VPN_W-1:0] v);
    logic [PA_W-1:0] a;
    a = cur_base + PA_W'({v, 2'b00});
    return a[9:2];
  endfunction

  task automatic walk(logic [VPN_W-1:0] vpn, logic [31:0] pte, logic wr,
                      logic ev, logic [VPN_W-1:0] evv, logic [31:0] evpte,
                      int lat, logic poke_busy);
    logic [31:0] newp, va;
    logic [7:0]  pi, ei, ii;
    logic        efault, eprot, epwb, eewb;
    int rd0, wr0, k;
    bit got;
    pi = widx(vpn); ei = widx(evv); ii = widx(20'd200);
    poke(pi, pte);
    if (ev) poke(ei, evpte);
    if (poke_busy) poke(ii, 32'h0000_0001);
    lat_cfg = lat;
    va = {vpn, 12'(vpn * 13)};
    efault = !pte[0] || (wr && !pte[1]);
    eprot  = pte[0] && wr && !pte[1];
    newp   = pte | 32'h4 | (wr ? 32'h8 : 32'h0);
    epwb   = !efault && (newp != pte);
    eewb   = ev && !evpte[3];
    @(negedge clk);
    rd0 = n_rd; wr0 = n_wr;
    miss_valid = 1'b1; miss_vaddr = va; miss_write = wr;
    evict_dirty = ev; evict_vpn = evv;
    @(negedge clk);
    miss_valid = 1'b0; evict_dirty = 1'b0;
    chk("R8", "busy after accept", {31'd0, busy}, 32'd1);
    got = 0;
    for (k = 0; k < 60 && !got; k++) begin
      if (fill_valid || fault_valid) got = 1;
      else begin
        if (poke_busy && k == 1) begin
          miss_valid = 1'b1; miss_vaddr = {20'd200, 12'h0}; miss_write = 1'b1;
        end else miss_valid = 1'b0;
        @(negedge clk);
      end
    end
    miss_valid = 1'b0;
    chk("R3", "pulse one cycle after last response", cyc - rsp_cyc, 32'd1);
    chk("R8", "busy during pulse", {31'd0, busy}, 32'd1);
    if (efault) begin
      chk("R5", "fault pulse", {30'd0, fault_valid, fill_valid}, 32'h2);
      chk(eprot ? "R6" : "R5", "fault_prot", {31'd0, fault_prot}, {31'd0, eprot});
      chk(eprot ? "R6" : "R5", "bad_vaddr", bad_vaddr, va);
      last_fault_va = va;
    end else begin
      chk("R3", "fill pulse", {30'd0, fault_valid, fill_valid}, 32'h1);
      chk("R3", "fill_vpn", 32'(fill_vpn), 32'(vpn));
      chk("R3", "fill_ppn", 32'(fill_ppn), 32'(pte[29:12]));
      chk("R3", "fill_writable", {31'd0, fill_writable}, {31'd0, pte[1]});
      chk("R4", "fill_dirty", {31'd0, fill_dirty}, {31'd0, newp[3]});
      chk("R5", "bad_vaddr held", bad_vaddr, last_fault_va);
    end
    @(negedge clk);
    chk("R8", "busy low after pulse", {31'd0, busy, fill_valid, fault_valid}, 32'd0);
    chk("R2", "last read address", 32'(last_rd_addr), 32'(cur_base + PA_W'({vpn, 2'b00})));
    chk("R7", "read count", n_rd - rd0, ev ? 32'd2 : 32'd1);
    chk("R4", "write count", n_wr - wr0, 32'(epwb) + 32'(eewb));
    chk(eprot ? "R6" : "R4", "table entry after walk", mem[pi], epwb ? newp : pte);
    if (ev) chk("R7", "evicted entry", mem[ei], evpte | 32'h8);
    if (poke_busy) chk("R8", "ignored miss entry untouched", mem[ii], 32'h1);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset outputs",
        {27'd0, busy, fill_valid, fault_valid, fault_prot, mem_req_valid}, 32'd0);
    chk("R1", "reset bad_vaddr", bad_vaddr, 32'd0);
    // default base 0: vpn 5 at word 5
    walk(20'd5, 32'h0001_2003, 1'b0, 1'b0, '0, '0, 0, 1'b0);
    set_base(30'h100);
    for (int v = 0; v < 64; v++) begin
      logic [31:0] p, e;
      p = (32'((v * 37 + 5) & 32'h3FFFF) << 12) | 32'(v & 15);
      e = (32'((v * 11 + 3) & 32'h3FFFF) << 12) | 32'((v * 3) & 15);
      walk(20'(v), p, v[4], v[5], 20'(64 + v), e, v % 4, (v % 5) == 0);
    end
    chk("R9", "overlapping requests", 32'(ovl), 32'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule